// File: doc/BRIEF.md
# Interrupt Acknowledge Gate

This block decides, once per instruction boundary, whether the CPU accepts a pending interrupt and which source it accepts. Its inputs are one non-maskable request and, for each maskable source, a request flag, a mask flag and a priority flag. It also holds the global interrupt-enable flag and the in-service priority flag as internal state. When a request wins, the block raises a one-cycle acknowledge and reports three things: whether the non-maskable request was taken, the index of the winning maskable source, and that source's priority level.

Maskable requests use two priority levels. The in-service priority flag reads 0 while a high-priority handler runs. In that state every low-priority maskable request is held off, and only a high-priority request can interrupt the handler. Every acknowledge clears the global enable automatically. Acknowledging a high-priority source also writes the in-service flag to 0. The sequencer sets and clears the enable with pulse inputs and restores the in-service flag through a load port when a handler returns.

Top module: `irq_ack_gate`

## Requirements
- R1: After synchronous reset `ack` is 0, `ie_flag` is 0 and `isp_flag` is 1.
- R2: While `ie_flag` is 0, no maskable request is acknowledged, and a non-maskable request is still acknowledged.
- R3: A maskable source whose `irq_mask` bit is 1 is never acknowledged, whatever its priority bit.
- R4: While `isp_flag` is 0, maskable sources whose `irq_prio` bit is 1 (low level) are not acknowledged, and sources whose bit is 0 (high level) remain eligible.
- R5: While `isp_flag` is 1, sources of both levels are eligible, and any eligible high-level source wins over every eligible low-level source, whatever their indices.
- R6: Among eligible sources of the same level, the lowest index wins.
- R7: A pending `nmi_req` wins over all maskable requests. Its acknowledge has `ack_nmi` = 1 and `ack_lvl` = 0.
- R8: `ack` is high for the one cycle after a rising clock edge at which `at_boundary` was 1 and some request was eligible. It is never high at any other time.
- R9: `ie_flag` reads 0 in the cycle `ack` is high, even if `ei_set` was pulsed at the same edge.
- R10: Acknowledging a high-level maskable source writes `isp_flag` to 0. Acknowledging a low-level source or the non-maskable request leaves `isp_flag` unchanged.
- R11: `ei_set` sets `ie_flag` and `di_clr` clears it, with `di_clr` winning if both are pulsed. `isp_load` writes `isp_value` into `isp_flag` unless an acknowledge at the same edge clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_req | input | 1 | Non-maskable request pending |
| irq_req | input | NUM_SRC | Maskable request flags |
| irq_mask | input | NUM_SRC | Per-source mask, 1 = blocked |
| irq_prio | input | NUM_SRC | Per-source level, 0 = high, 1 = low |
| at_boundary | input | 1 | Instruction boundary, acknowledge allowed |
| ei_set | input | 1 | Pulse: set interrupt enable |
| di_clr | input | 1 | Pulse: clear interrupt enable |
| isp_load | input | 1 | Pulse: load in-service priority flag |
| isp_value | input | 1 | Value for isp_load |
| ack | output | 1 | One-cycle acknowledge strobe |
| ack_nmi | output | 1 | Acknowledge was for the non-maskable request |
| ack_idx | output | IDX_W | Index of the acknowledged maskable source |
| ack_lvl | output | 1 | Level of the acknowledged source, 0 = high |
| ie_flag | output | 1 | Interrupt enable flag |
| isp_flag | output | 1 | In-service priority flag |

## Verification
The bench builds the block with the default of eight maskable sources, which gives a three-bit index. With eight sources, requests can sit at both ends of the vector, index 0 and index 7, and a low-index low-level request can be set against a high-index high-level one. Those are the cases where a wrong level-over-index ordering would show. The bench reaches each combination of enable flag and in-service flag through the block's own pulse and load inputs. It also drives collisions at a single edge, such as an enable pulse landing on the same edge as an acknowledge.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

    typedef enum logic {
        LVL_HIGH = 1'b0,
        LVL_LOW  = 1'b1
    } irq_lvl_e;

    typedef struct packed {
        logic     valid;
        logic     nmi;
        irq_lvl_e lvl;
    } pick_s;

    // A maskable source may be taken when enabled, requested, unmasked,
    // and either the in-service flag admits all levels or it is high level.
    function automatic logic src_eligible(
        input logic req,
        input logic mask,
        input logic prio,
        input logic ie,
        input logic isp
    );
        return ie & req & ~mask & (isp | ~prio);
    endfunction

endpackage

// File: rtl/irq_eligible.sv
module irq_eligible
    import irq_gate_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic [NUM_SRC-1:0] req,
    input  logic [NUM_SRC-1:0] mask,
    input  logic [NUM_SRC-1:0] prio,
    input  logic               ie,
    input  logic               isp,
    output logic [NUM_SRC-1:0] hi_vec,
    output logic [NUM_SRC-1:0] lo_vec
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic ok;
        assign ok        = src_eligible(req[g], mask[g], prio[g], ie, isp);
        assign hi_vec[g] = ok & ~prio[g];
        assign lo_vec[g] = ok &  prio[g];
    end

endmodule

// File: rtl/irq_first_set.sv
module irq_first_set #(
    parameter int W  = 8,
    parameter int IW = 3
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/irq_flag_regs.sv
module irq_flag_regs (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic take_high,
    input  logic ei_set,
    input  logic di_clr,
    input  logic isp_load,
    input  logic isp_value,
    output logic ie,
    output logic isp
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ie  <= 1'b0;
            isp <= 1'b1;
        end else begin
            if (take || di_clr)
                ie <= 1'b0;
            else if (ei_set)
                ie <= 1'b1;

            if (take_high)
                isp <= 1'b0;
            else if (isp_load)
                isp <= isp_value;
        end
    end

    // R11
    di_clears_ie_chk: assert property (@(posedge clk) disable iff (rst)
        $past(di_clr) |-> !ie);

    // R11
    ei_sets_ie_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(ei_set) && !$past(di_clr) && !$past(take)) |-> ie);

endmodule

// File: rtl/irq_ack_gate.sv
module irq_ack_gate
    import irq_gate_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               nmi_req,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [NUM_SRC-1:0] irq_mask,
    input  logic [NUM_SRC-1:0] irq_prio,
    input  logic               at_boundary,
    input  logic               ei_set,
    input  logic               di_clr,
    input  logic               isp_load,
    input  logic               isp_value,
    output logic               ack,
    output logic               ack_nmi,
    output logic [IDX_W-1:0]   ack_idx,
    output logic               ack_lvl,
    output logic               ie_flag,
    output logic               isp_flag
);

    logic [NUM_SRC-1:0] hi_vec, lo_vec;
    logic               hi_found, lo_found;
    logic [IDX_W-1:0]   hi_idx, lo_idx;
    pick_s              pick;
    logic [IDX_W-1:0]   pick_idx;
    logic               take, take_high;

    irq_eligible #(.NUM_SRC(NUM_SRC)) u_elig (
        .req    (irq_req),
        .mask   (irq_mask),
        .prio   (irq_prio),
        .ie     (ie_flag),
        .isp    (isp_flag),
        .hi_vec (hi_vec),
        .lo_vec (lo_vec)
    );

    irq_first_set #(.W(NUM_SRC), .IW(IDX_W)) u_hi_pick (
        .vec   (hi_vec),
        .found (hi_found),
        .idx   (hi_idx)
    );

    irq_first_set #(.W(NUM_SRC), .IW(IDX_W)) u_lo_pick (
        .vec   (lo_vec),
        .found (lo_found),
        .idx   (lo_idx)
    );

    always_comb begin
        pick     = '{valid: 1'b0, nmi: 1'b0, lvl: LVL_HIGH};
        pick_idx = '0;
        if (nmi_req) begin
            pick = '{valid: 1'b1, nmi: 1'b1, lvl: LVL_HIGH};
        end else if (hi_found) begin
            pick     = '{valid: 1'b1, nmi: 1'b0, lvl: LVL_HIGH};
            pick_idx = hi_idx;
        end else if (lo_found) begin
            pick     = '{valid: 1'b1, nmi: 1'b0, lvl: LVL_LOW};
            pick_idx = lo_idx;
        end
    end

    assign take      = at_boundary & pick.valid;
    assign take_high = take & ~pick.nmi & (pick.lvl == LVL_HIGH);

    irq_flag_regs u_flags (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .take_high (take_high),
        .ei_set    (ei_set),
        .di_clr    (di_clr),
        .isp_load  (isp_load),
        .isp_value (isp_value),
        .ie        (ie_flag),
        .isp       (isp_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ack     <= 1'b0;
            ack_nmi <= 1'b0;
            ack_idx <= '0;
            ack_lvl <= 1'b0;
        end else begin
            ack <= take;
            if (take) begin
                ack_nmi <= pick.nmi;
                ack_idx <= pick_idx;
                ack_lvl <= pick.lvl;
            end
        end
    end

    // R8
    ack_after_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(at_boundary));

    // R9
    ack_clears_ie_chk: assert property (@(posedge clk) disable iff (rst)
        ack |-> !ie_flag);

    // R2
    maskable_needs_ie_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !ack_nmi) |-> $past(ie_flag));

    // R3
    masked_never_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !ack_nmi) |-> !$past(irq_mask[ack_idx]));

    // R4
    low_needs_isp_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !ack_nmi && ack_lvl) |-> $past(isp_flag));

    // R7
    nmi_first_chk: assert property (@(posedge clk) disable iff (rst)
        ack |-> (ack_nmi == $past(nmi_req)));

    // R10
    high_clears_isp_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !ack_nmi && !ack_lvl) |-> !isp_flag);

endmodule

// File: tb/irq_ack_gate_test.sv
`timescale 1ns/1ps
module irq_ack_gate_test;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         nmi_req;
    logic [N-1:0] irq_req, irq_mask, irq_prio;
    logic         at_boundary, ei_set, di_clr, isp_load, isp_value;
    logic         ack, ack_nmi, ack_lvl, ie_flag, isp_flag;
    logic [2:0]   ack_idx;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irq_ack_gate #(.NUM_SRC(N)) uut (
        .clk(clk), .rst(rst), .nmi_req(nmi_req), .irq_req(irq_req),
        .irq_mask(irq_mask), .irq_prio(irq_prio), .at_boundary(at_boundary),
        .ei_set(ei_set), .di_clr(di_clr), .isp_load(isp_load),
        .isp_value(isp_value), .ack(ack), .ack_nmi(ack_nmi),
        .ack_idx(ack_idx), .ack_lvl(ack_lvl), .ie_flag(ie_flag),
        .isp_flag(isp_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        nmi_req = 0; irq_req = '0; irq_mask = '0; irq_prio = '0;
        at_boundary = 0; ei_set = 0; di_clr = 0; isp_load = 0; isp_value = 0;
    endtask

    // set both flags through the pulse/load inputs
    task automatic prep(input logic ie, input logic isp);
        @(negedge clk);
        ei_set = ie; di_clr = ~ie; isp_load = 1; isp_value = isp;
        @(negedge clk);
        ei_set = 0; di_clr = 0; isp_load = 0;
        chk("R11 ie after pulse", ie_flag, ie);
        chk("R11 isp after load", isp_flag, isp);
    endtask

    // one boundary with the given requests; outputs sampled one cycle later
    task automatic fire(input logic [N-1:0] rq, input logic [N-1:0] mk,
                        input logic [N-1:0] pr, input logic nmi);
        @(negedge clk);
        irq_req = rq; irq_mask = mk; irq_prio = pr; nmi_req = nmi;
        at_boundary = 1;
        @(negedge clk);
        at_boundary = 0; irq_req = '0; nmi_req = 0;
    endtask

    task automatic t_reset();
        chk("R1 ack", ack, 0);
        chk("R1 ie", ie_flag, 0);
        chk("R1 isp", isp_flag, 1);
    endtask

    task automatic t_ie_off();
        prep(0, 1);
        fire(8'h04, 8'h00, 8'h00, 0);
        chk("R2 no maskable ack when ie=0", ack, 0);
        fire(8'h04, 8'h00, 8'h00, 1);
        chk("R2 nmi acked when ie=0", ack, 1);
        chk("R7 ack_nmi", ack_nmi, 1);
        chk("R7 nmi level", ack_lvl, 0);
        chk("R10 nmi keeps isp", isp_flag, 1);
        @(negedge clk);
        chk("R8 strobe single cycle", ack, 0);
    endtask

    task automatic t_mask();
        prep(1, 1);
        fire(8'h88, 8'h88, 8'h80, 0);
        chk("R3 masked not acked", ack, 0);
        chk("R3 ie untouched", ie_flag, 1);
    endtask

    task automatic t_isp_zero();
        prep(1, 0);
        fire(8'h02, 8'h00, 8'h02, 0);
        chk("R4 low blocked when isp=0", ack, 0);
        fire(8'h22, 8'h00, 8'h02, 0);
        chk("R4 high acked when isp=0", ack, 1);
        chk("R4 idx", ack_idx, 5);
        chk("R4 lvl", ack_lvl, 0);
        chk("R9 ie cleared", ie_flag, 0);
    endtask

    task automatic t_levels();
        prep(1, 1);
        fire(8'h41, 8'h00, 8'h01, 0);
        chk("R5 ack", ack, 1);
        chk("R5 high beats lower index low", ack_idx, 6);
        chk("R5 lvl", ack_lvl, 0);
        chk("R10 high clears isp", isp_flag, 0);
        prep(1, 1);
        fire(8'h11, 8'h00, 8'h11, 0);
        chk("R6 low-level lowest index", ack_idx, 0);
        chk("R6 lvl", ack_lvl, 1);
        chk("R10 low keeps isp", isp_flag, 1);
        prep(1, 1);
        fire(8'h84, 8'h00, 8'h00, 0);
        chk("R6 high-level lowest index", ack_idx, 2);
        prep(1, 1);
        fire(8'h80, 8'h00, 8'h80, 0);
        chk("R6 top index alone", ack_idx, 7);
    endtask

    task automatic t_boundary();
        prep(1, 1);
        @(negedge clk);
        irq_req = 8'h08;
        @(negedge clk);
        chk("R8 no ack without boundary", ack, 0);
        at_boundary = 1;
        @(negedge clk);
        at_boundary = 0; irq_req = '0;
        chk("R8 ack after boundary", ack, 1);
        chk("R8 idx", ack_idx, 3);
        @(negedge clk);
        chk("R8 strobe drops", ack, 0);
    endtask

    task automatic t_nmi_wins();
        prep(1, 1);
        fire(8'h08, 8'h00, 8'h00, 1);
        chk("R7 nmi over maskable", ack_nmi, 1);
        chk("R9 ie cleared by nmi", ie_flag, 0);
        chk("R10 nmi keeps isp", isp_flag, 1);
    endtask

    task automatic t_collide();
        prep(1, 1);
        @(negedge clk);
        irq_req = 8'h01; at_boundary = 1; ei_set = 1;
        @(negedge clk);
        irq_req = '0; at_boundary = 0; ei_set = 0;
        chk("R9 ack beats ei_set", ie_flag, 0);
        @(negedge clk);
        ei_set = 1; di_clr = 1;
        @(negedge clk);
        ei_set = 0; di_clr = 0;
        chk("R11 di beats ei", ie_flag, 0);
        prep(1, 1);
        @(negedge clk);
        irq_req = 8'h02; at_boundary = 1; isp_load = 1; isp_value = 1;
        @(negedge clk);
        irq_req = '0; at_boundary = 0; isp_load = 0;
        chk("R11 ack clear beats isp_load", isp_flag, 0);
    endtask

    initial begin
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_ie_off();
        t_mask();
        t_isp_zero();
        t_levels();
        t_boundary();
        t_nmi_wins();
        t_collide();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule